// File: doc/BRIEF.md
# Configuration Request Retry Engine

This block sits in a root port between a configuration-access front end and the transaction layer. It takes one configuration read or write at a time and builds the outgoing configuration address word. It sends the request downstream and watches the completion status that comes back. When the completer answers with retry status (status code 2), the engine waits a programmable number of cycles and then sends the same request again. It keeps doing this until it gets a different status or until a programmable cycle budget, counted from the moment the request was accepted, has run out.

Software visibility needs special handling. With the visibility enable high, a read that covers the Vendor ID bytes and gets retry status is not sent again. Instead it finishes at once with the synthetic word 0xFFFF0001. Every other access is always retried, including writes and reads of other offsets. When the budget is gone, a read finishes with all-ones data and a write is dropped. In both cases the error flag is raised and a sticky abort bit is set. Reads of one or two bytes return only the addressed lanes.

The request port and the response port both use valid/ready. A request is taken only on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low for the whole time a transaction is open. A response stays presented, and its values stay fixed, until `rsp_ready` takes it. The downstream request stays on `dn_valid` until `dn_ready` accepts it. Completions have no back-pressure.

Top module: `cfg_retry_engine`

## Requirements
- R1: `req_ready` is high only when no transaction is open. `busy` is high from the accept edge until the edge on which the response is taken. A request offered while `busy` is high is held off.
- R2: `dn_addr` packs the bus in [31:24], the device in [23:19], the function in [18:16], zeros in [15:12], the dword offset `req_reg[11:2]` in [11:2], a zero in bit 1, and in bit 0 a type bit that is 1 when the bus number is not zero. `dn_write` and `dn_wdata` carry the request's direction and write data.
- R3: A completion with any status other than 2 ends the transaction. A read returns the completion data, `rsp_err` is 0 and `rsp_crs` is 0.
- R4: A status-2 completion that is retried causes the same request to reappear on `dn_valid` exactly `retry_gap`+2 cycles after the cycle in which the completion was presented. `retry_count` then reports the number of reissues the last transaction needed.
- R5: With `sv_enable` high, a read with `req_reg[11:1]` equal to 0 that gets status 2 is not retried. It returns 0xFFFF0001, with lane extraction applied, and `rsp_err` is 0.
- R6: With `sv_enable` high, status 2 on any write, or on a read at any other offset, is still retried.
- R7: A status-2 completion sampled on the edge E(k), where k is the number of edges after the accept edge, exhausts the budget when k-1 >= `retry_budget`. A read then returns all ones after lane extraction, a write returns data 0, and `rsp_err` is 1.
- R8: `rsp_crs` is high together with `rsp_valid` exactly when the budget ran out and `sv_enable` is low. It is never high while `sv_enable` is high.
- R9: A `req_size` of 1 or 2 returns the dword shifted right by 8×`req_reg[1:0]` and masked to 8 or 16 bits. Any other size returns the whole dword. Write responses carry data 0.
- R10: `abort_flag` resets to 0 and is set when a response with `rsp_err` is produced. A pulse on `abort_clr` clears it, and setting wins over clearing.
- R11: `rsp_data`, `rsp_err` and `rsp_valid` hold steady while `rsp_ready` is low. `dn_valid` and `dn_addr` hold while `dn_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sv_enable | input | 1 | Software-visibility enable for Vendor ID reads |
| retry_gap | input | CW | Wait cycles between a retry completion and the reissue |
| retry_budget | input | CW | Cycle budget counted from accept |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_reg | input | 12 | Register byte offset |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_write | output | 1 | Downstream direction |
| dn_addr | output | 32 | Packed configuration address word |
| dn_wdata | output | 32 | Downstream write data |
| cpl_valid | input | 1 | Completion present |
| cpl_status | input | 3 | Completion status, 2 = retry |
| cpl_data | input | 32 | Completion dword |
| rsp_valid | output | 1 | Final response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 32 | Response data |
| rsp_err | output | 1 | Transaction failed |
| rsp_crs | output | 1 | Retry status visible with the response |
| busy | output | 1 | Transaction open |
| retry_count | output | RCW | Reissues needed by the last transaction |
| abort_flag | output | 1 | Sticky received-abort bit |
| abort_clr | input | 1 | Clears `abort_flag` (write-one-to-clear) |

## Verification
The hardest case to reach from the ports is budget exhaustion after several reissues. It depends on how many cycles have passed since accept at the moment a retry completion arrives, and that in turn depends on completer latency and gap length. The bench's completer stub keeps answering with status 2 while it counts edges from the accept edge itself. It uses a small budget and a short gap so that exhaustion lands on a later attempt. From that count it predicts which completion trips the budget and how many reissues came before it. The software-visibility rule is covered from both sides: a Vendor ID read, a Device ID read and a write are each sent with the enable high.

// File: rtl/cfg_retry_pkg.sv
package cfg_retry_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_GAP,
    S_RESP
  } cre_state_e;

  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int REG_W = 12;
  localparam int DW    = 32;

  localparam logic [2:0]    CPL_RETRY   = 3'd2;
  localparam logic [DW-1:0] VENDOR_HOLD = 32'hFFFF_0001;

  // bus | device | function | zero | dword offset | zero | type bit
  function automatic logic [DW-1:0] pack_cfg_addr(
    input logic [BUS_W-1:0] bus,
    input logic [DEV_W-1:0] dev,
    input logic [FN_W-1:0]  fn,
    input logic [REG_W-1:0] regoff
  );
    return {bus, dev, fn, 4'b0000, regoff[11:2], 1'b0, (bus != '0)};
  endfunction

endpackage

// File: rtl/cre_budget_timer.sv
module cre_budget_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
    end else if (restart) begin
      elapsed <= '0;
    end else if (run && (elapsed != '1)) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assign expired = (elapsed >= limit);
endmodule

// File: rtl/cre_lane_extract.sv
module cre_lane_extract #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] dword,
  input  logic [1:0]    lane,
  input  logic [2:0]    size,
  output logic [DW-1:0] value
);
  logic [DW-1:0] shifted;

  assign shifted = dword >> {lane, 3'b000};

  always_comb begin
    case (size)
      3'd1:    value = {{(DW-8){1'b0}}, shifted[7:0]};
      3'd2:    value = {{(DW-16){1'b0}}, shifted[15:0]};
      default: value = dword;
    endcase
  end
endmodule

// File: rtl/cfg_retry_engine.sv
module cfg_retry_engine
  import cfg_retry_pkg::*;
#(
  parameter int CW  = 32,
  parameter int RCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sv_enable,
  input  logic [CW-1:0]  retry_gap,
  input  logic [CW-1:0]  retry_budget,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [7:0]     req_bus,
  input  logic [4:0]     req_dev,
  input  logic [2:0]     req_fn,
  input  logic [11:0]    req_reg,
  input  logic [2:0]     req_size,
  input  logic [31:0]    req_wdata,
  output logic           dn_valid,
  input  logic           dn_ready,
  output logic           dn_write,
  output logic [31:0]    dn_addr,
  output logic [31:0]    dn_wdata,
  input  logic           cpl_valid,
  input  logic [2:0]     cpl_status,
  input  logic [31:0]    cpl_data,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [31:0]    rsp_data,
  output logic           rsp_err,
  output logic           rsp_crs,
  output logic           busy,
  output logic [RCW-1:0] retry_count,
  output logic           abort_flag,
  input  logic           abort_clr
);
  cre_state_e st;

  logic          t_write;
  logic [7:0]    t_bus;
  logic [4:0]    t_dev;
  logic [2:0]    t_fn;
  logic [11:0]   t_reg;
  logic [2:0]    t_size;
  logic [31:0]   t_wdata;
  logic [31:0]   raw;
  logic          fin_err;
  logic          fin_crs;
  logic [CW-1:0] gcnt;
  logic [RCW-1:0] rcnt;

  logic accept, expired, is_retry, vendor_hit, exhaust_now;
  logic [31:0] shaped;

  assign accept      = (st == S_IDLE) && req_valid;
  assign is_retry    = cpl_valid && (cpl_status == CPL_RETRY);
  assign vendor_hit  = sv_enable && !t_write && (t_reg[11:1] == 11'd0);
  assign exhaust_now = (st == S_WAIT) && is_retry && !vendor_hit && expired;

  cre_budget_timer #(.CW(CW)) u_budget (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     ((st == S_ISSUE) || (st == S_WAIT) || (st == S_GAP)),
    .limit   (retry_budget),
    .expired (expired)
  );

  cre_lane_extract #(.DW(32)) u_lane (
    .dword (raw),
    .lane  (t_reg[1:0]),
    .size  (t_size),
    .value (shaped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      t_write <= 1'b0;
      t_bus   <= '0;
      t_dev   <= '0;
      t_fn    <= '0;
      t_reg   <= '0;
      t_size  <= '0;
      t_wdata <= '0;
      raw     <= '0;
      fin_err <= 1'b0;
      fin_crs <= 1'b0;
      gcnt    <= '0;
      rcnt    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          t_write <= req_write;
          t_bus   <= req_bus;
          t_dev   <= req_dev;
          t_fn    <= req_fn;
          t_reg   <= req_reg;
          t_size  <= req_size;
          t_wdata <= req_wdata;
          rcnt    <= '0;
          st      <= S_ISSUE;
        end
        S_ISSUE: if (dn_ready) st <= S_WAIT;
        S_WAIT: if (cpl_valid) begin
          if (!is_retry) begin
            raw <= cpl_data; fin_err <= 1'b0; fin_crs <= 1'b0; st <= S_RESP;
          end else if (vendor_hit) begin
            raw <= VENDOR_HOLD; fin_err <= 1'b0; fin_crs <= 1'b0; st <= S_RESP;
          end else if (expired) begin
            raw <= '1; fin_err <= 1'b1; fin_crs <= 1'b1; st <= S_RESP;
          end else begin
            gcnt <= retry_gap;
            st   <= S_GAP;
          end
        end
        S_GAP: begin
          if (gcnt == '0) begin
            st <= S_ISSUE;
            if (rcnt != '1) rcnt <= rcnt + 1'b1;
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           abort_flag <= 1'b0;
    else if (exhaust_now) abort_flag <= 1'b1;
    else if (abort_clr)   abort_flag <= 1'b0;
  end

  assign req_ready   = (st == S_IDLE);
  assign busy        = (st != S_IDLE);
  assign dn_valid    = (st == S_ISSUE);
  assign dn_write    = t_write;
  assign dn_addr     = pack_cfg_addr(t_bus, t_dev, t_fn, t_reg);
  assign dn_wdata    = t_wdata;
  assign rsp_valid   = (st == S_RESP);
  assign rsp_data    = t_write ? 32'd0 : shaped;
  assign rsp_err     = fin_err;
  assign rsp_crs     = rsp_valid && fin_crs && !sv_enable;
  assign retry_count = rcnt;
endmodule

// File: rtl/cfg_retry_engine_chk.sv
module cfg_retry_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sv_enable,
  input logic        req_ready,
  input logic        busy,
  input logic        dn_valid,
  input logic        dn_ready,
  input logic [31:0] dn_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        rsp_err,
  input logic        rsp_crs,
  input logic        abort_flag
);
  a_r1_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && busy));

  a_r1_rsp_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy);

  a_r1_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dn_valid, rsp_valid}));

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  a_r11_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr)));

  a_r8_no_crs_visible: assert property (@(posedge clk) disable iff (!rst_n)
    sv_enable |-> !rsp_crs);

  a_r10_abort_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_err) |-> abort_flag);
endmodule

bind cfg_retry_engine cfg_retry_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sv_enable  (sv_enable),
  .req_ready  (req_ready),
  .busy       (busy),
  .dn_valid   (dn_valid),
  .dn_ready   (dn_ready),
  .dn_addr    (dn_addr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .rsp_err    (rsp_err),
  .rsp_crs    (rsp_crs),
  .abort_flag (abort_flag)
);

// File: tb/sim_cfg_retry_engine.sv
`timescale 1ns/1ps
module sim_cfg_retry_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        sv_enable = 1'b0;
  logic [31:0] retry_gap = 32'd3;
  logic [31:0] retry_budget = 32'd1000;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [11:0] req_reg = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        req_ready, dn_valid, dn_write;
  logic        dn_ready = 1'b1;
  logic [31:0] dn_addr, dn_wdata;
  logic        cpl_valid = 1'b0;
  logic [2:0]  cpl_status = '0;
  logic [31:0] cpl_data = '0;
  logic        rsp_valid, rsp_err, rsp_crs, busy, abort_flag;
  logic        rsp_ready = 1'b0;
  logic        abort_clr = 1'b0;
  logic [31:0] rsp_data;
  logic [15:0] retry_count;

  cfg_retry_engine u0 (.*);

  int total = 0, bad = 0, cyc = 0;
  bit in_txn = 0;
  bit m_abort = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    cyc++;
    @(negedge clk);
    if (in_txn) chk(busy && !req_ready, "R1 busy/ready while open", {30'd0, busy, req_ready}, 32'd2);
  endtask

  function automatic logic [31:0] lanes(input logic [31:0] dw, input logic [11:0] r, input logic [2:0] sz);
    logic [31:0] s;
    s = dw >> (8 * r[1:0]);
    if (sz == 3'd1) return s & 32'h0000_00FF;
    if (sz == 3'd2) return s & 32'h0000_FFFF;
    return dw;
  endfunction

  task automatic run_txn(input bit w, input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                         input logic [11:0] r, input logic [2:0] sz, input logic [31:0] wd,
                         input int n_crs, input logic [2:0] fin_st, input logic [31:0] okd,
                         input int lat, input int hold);
    logic [31:0] exp_addr, exp_data;
    int attempt, retries, m, waitn;
    bit done, fail, svhit, gap_ok;
    exp_addr = {b, d, f, 4'b0000, r[11:2], 1'b0, (b != 8'd0)};
    chk(req_ready, "R1 ready when idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1; req_write = w; req_bus = b; req_dev = d; req_fn = f;
    req_reg = r; req_size = sz; req_wdata = wd;
    tick();
    req_valid = 0; req_bus = 8'hEE; cyc = 0; in_txn = 1;
    attempt = 0; retries = 0; done = 0; fail = 0; svhit = 0;
    while (!done) begin
      waitn = 0;
      while (!dn_valid && waitn < 64) begin tick(); waitn++; end
      chk(dn_valid && dn_addr == exp_addr, "R2 address word", dn_addr, exp_addr);
      chk(dn_write == w && (!w || dn_wdata == wd), "R2 direction/data", dn_wdata, w ? wd : dn_wdata);
      tick();
      repeat (lat) tick();
      cpl_valid = 1; cpl_status = (attempt < n_crs) ? 3'd2 : fin_st; cpl_data = okd; m = cyc;
      tick();
      cpl_valid = 0;
      if (attempt >= n_crs) done = 1;
      else if (sv_enable && !w && r[11:1] == 11'd0) begin svhit = 1; done = 1; end
      else if (m >= int'(retry_budget)) begin fail = 1; done = 1; end
      else begin
        gap_ok = 1;
        for (int i = 0; i <= int'(retry_gap); i++) begin
          if (dn_valid) gap_ok = 0;
          tick();
        end
        chk(gap_ok && dn_valid, "R4 reissue spacing", {31'd0, dn_valid}, 32'd1);
        retries++;
      end
      attempt++;
    end
    if (w) exp_data = 32'd0;
    else if (fail) exp_data = lanes(32'hFFFF_FFFF, r, sz);
    else if (svhit) exp_data = lanes(32'hFFFF_0001, r, sz);
    else exp_data = lanes(okd, r, sz);
    if (fail) m_abort = 1;
    for (int i = 0; i < hold; i++) begin
      chk(rsp_valid && rsp_data == exp_data, "R11 response held", rsp_data, exp_data);
      tick();
    end
    chk(rsp_valid, "R3 response presented", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_data == exp_data, fail ? "R7 exhausted data" : (svhit ? "R5 vendor word" : "R9 read data"), rsp_data, exp_data);
    chk(rsp_err == fail, "R7 error flag", {31'd0, rsp_err}, {31'd0, fail});
    chk(rsp_crs == (fail && !sv_enable), "R8 crs indication", {31'd0, rsp_crs}, {31'd0, fail && !sv_enable});
    chk(retry_count == retries[15:0], "R4 retry count", {16'd0, retry_count}, retries);
    rsp_ready = 1; in_txn = 0;
    tick();
    rsp_ready = 0;
    chk(!busy && !rsp_valid && req_ready, "R1 idle after take", {30'd0, busy, rsp_valid}, 32'd0);
    chk(abort_flag == m_abort, "R10 abort flag", {31'd0, abort_flag}, {31'd0, m_abort});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && req_ready && !dn_valid && !rsp_valid, "R1 reset state", {29'd0, busy, dn_valid, rsp_valid}, 32'd0);
    chk(!abort_flag, "R10 reset abort", {31'd0, abort_flag}, 32'd0);

    // R3 R9: plain dword read, no retry
    run_txn(0, 8'd1, 5'd3, 3'd2, 12'h010, 3'd4, 0, 0, 3'd0, 32'hA1B2C3D4, 2, 0);
    // R4 R9 R11: byte read, lane 3, two retries, held response
    run_txn(0, 8'd4, 5'd31, 3'd7, 12'hFF3, 3'd1, 0, 2, 3'd0, 32'h5566_7788, 1, 3);
    // R9: halfword lane 2, one retry, longer gap
    retry_gap = 32'd6;
    run_txn(0, 8'd2, 5'd1, 3'd0, 12'h00E, 3'd2, 0, 1, 3'd0, 32'hBEEF_1234, 0, 0);
    retry_gap = 32'd3;
    // R3: other non-retry status on root bus (type bit 0)
    run_txn(0, 8'd0, 5'd0, 3'd1, 12'h104, 3'd4, 0, 0, 3'd1, 32'h0BAD_F00D, 3, 0);
    // R5: vendor id read with visibility on
    sv_enable = 1;
    run_txn(0, 8'd1, 5'd0, 3'd0, 12'h000, 3'd4, 0, 5, 3'd0, 32'h1111_2222, 1, 0);
    run_txn(0, 8'd1, 5'd0, 3'd0, 12'h000, 3'd2, 0, 5, 3'd0, 32'h1111_2222, 0, 0);
    // R6: device id read and a write at offset 0 are still retried
    run_txn(0, 8'd1, 5'd0, 3'd0, 12'h002, 3'd2, 0, 1, 3'd0, 32'h9ABC_8086, 1, 0);
    run_txn(1, 8'd1, 5'd0, 3'd0, 12'h000, 3'd4, 32'hCAFE_0042, 2, 3'd0, 0, 1, 0);
    // R7 R8: write exhausted while visibility on (no crs indication)
    retry_budget = 32'd0;
    run_txn(1, 8'd3, 5'd2, 3'd1, 12'h040, 3'd4, 32'h1234_5678, 99, 3'd0, 0, 1, 0);
    sv_enable = 0;
    // R10: clear the sticky abort
    abort_clr = 1; tick(); abort_clr = 0; m_abort = 0;
    chk(!abort_flag, "R10 cleared by abort_clr", {31'd0, abort_flag}, 32'd0);
    // R7 R8: immediate exhaustion of a read, visibility off
    run_txn(0, 8'd1, 5'd0, 3'd0, 12'h000, 3'd4, 0, 99, 3'd0, 0, 0, 0);
    abort_clr = 1; tick(); abort_clr = 0; m_abort = 0;
    // R7: exhaustion after several reissues
    retry_budget = 32'd12; retry_gap = 32'd2;
    run_txn(0, 8'd9, 5'd4, 3'd3, 12'h086, 3'd2, 0, 99, 3'd0, 0, 1, 0);
    retry_budget = 32'd1000; retry_gap = 32'd3;
    // R10 R3: good read leaves the sticky bit set
    run_txn(0, 8'd5, 5'd5, 3'd5, 12'h021, 3'd1, 0, 0, 3'd0, 32'h00C3_0000, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule